// File: doc/BRIEF.md
# Interrupt Target Routing Registers

This block keeps, for every interrupt of an interrupt controller, an 8-bit mask naming the processors that may receive it. Software reaches the masks through a small memory-mapped port. Each interrupt takes one byte of the address space, so byte offset n belongs to interrupt n. An access is either a single byte or an aligned 32-bit word that covers four neighbouring interrupts.

Next to each mask the block keeps one concrete destination: the processor index that delivery logic should use. It is taken from the lowest set bit of the mask, and an empty mask falls back to processor 0. All masks and destinations are driven out as flat buses for the delivery logic.

The first 32 interrupts are private to each processor and have no storage. They always read as the bit of the processor making the access, and writes to them are dropped. Offsets at or beyond the configured interrupt count read as zero and drop writes.

Top module: `itr_target_bank`

## Requirements
- R1: After reset every shared interrupt's mask and routing index is 0, and `rd_valid` is 0.
- R2: A byte write (`req_word`=0) to offset n, with 32 <= n < NUM_IRQ, stores `req_wdata[7:0]` as the mask of interrupt n. The new value appears on `mask_o[8n+7:8n]` after the clock edge that takes the request.
- R3: A word write (`req_word`=1) ignores `req_addr[1:0]` and updates interrupts 4w to 4w+3, where w = `req_addr`>>2. Interrupt 4w+i takes `req_wdata[8i+7:8i]`.
- R4: Each routing index `route_o[3n+2:3n]` equals the position of the lowest set bit of that interrupt's mask. It updates in the same edge as the mask.
- R5: An interrupt whose mask is zero has routing index 0.
- R6: Writes to any interrupt below 32 are ignored. Each private interrupt's mask, on `mask_o` and on reads, equals 1 << `cpu_id`, and its routing index equals `cpu_id`.
- R7: A read returns data on `rd_data` one cycle after the request, with `rd_valid` high in that cycle only. A word read places interrupt 4w+i in bits 8i+7:8i. A byte read places interrupt n in bits 7:0 with the upper 24 bits zero.
- R8: Offsets at or beyond NUM_IRQ read as zero, and writes to them change no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_id | input | 3 | Index of the processor making the access |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| req_addr | input | ADDR_W | Byte offset (interrupt number) |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid pulse |
| mask_o | output | NUM_IRQ*8 | Target masks, interrupt n at bits 8n+7:8n |
| route_o | output | NUM_IRQ*3 | Routing indices, interrupt n at bits 3n+2:3n |

## Verification
Masks with one bit, several bits and no bits at all are written. Only the lowest-bit rule gives the expected index for all three, and the empty case shows the fallback to 0. Word writes use non-zero low address bits and a different pattern in every byte, which shows both the alignment and the lane order. Write attempts on private offsets, run under two different `cpu_id` values, and accesses just past the last interrupt show that nothing outside the shared range is touched.

// File: rtl/itr_pkg.sv
package itr_pkg;
   localparam int MASK_W  = 8;
   localparam int ROUTE_W = $clog2(MASK_W);
   localparam int LANES   = 4;
   localparam int PRIV_N  = 32;
   typedef logic [MASK_W-1:0]  mask_t;
   typedef logic [ROUTE_W-1:0] route_t;
endpackage

// File: rtl/itr_lowbit.sv
module itr_lowbit #(
   parameter int W = 8,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int k = W - 1; k >= 0; k--) begin
         if (vec[k]) idx = IW'(k);
      end
   end
endmodule

// File: rtl/itr_entry.sv
module itr_entry
   import itr_pkg::*;
#(
   parameter int IRQ_NUM = 32,
   parameter int ADDR_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output mask_t             mask_o,
   output route_t            route_o
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(IRQ_NUM);
   localparam int LANE = IRQ_NUM % LANES;

   logic   hit_word, hit_byte, wr_en;
   mask_t  wr_mask;
   route_t wr_route;

   assign hit_word = req_word && (req_addr[ADDR_W-1:2] == MY_ADDR[ADDR_W-1:2]);
   assign hit_byte = !req_word && (req_addr == MY_ADDR);
   assign wr_en    = req_valid && req_write && (hit_word || hit_byte);
   assign wr_mask  = req_word ? req_wdata[8*LANE +: 8] : req_wdata[7:0];

   itr_lowbit #(.W(MASK_W)) u_low (.vec(wr_mask), .idx(wr_route));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_o  <= '0;
         route_o <= '0;
      end else if (wr_en) begin
         mask_o  <= wr_mask;
         route_o <= wr_route;
      end
   end

   // R2
   wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mask_o == $past(wr_mask));
   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mask_o) && $stable(route_o));
   // R4
   route_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o != '0) |-> mask_o[route_o] &&
         ((mask_o & ((MASK_W'(1) << route_o) - MASK_W'(1))) == '0));
   // R5
   empty_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o == '0) |-> (route_o == '0));
endmodule

// File: rtl/itr_target_bank.sv
module itr_target_bank
   import itr_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int ADDR_W  = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ROUTE_W-1:0]         cpu_id,
   input  logic                       req_valid,
   input  logic                       req_write,
   input  logic                       req_word,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [31:0]                req_wdata,
   output logic [31:0]                rd_data,
   output logic                       rd_valid,
   output logic [NUM_IRQ*MASK_W-1:0]  mask_o,
   output logic [NUM_IRQ*ROUTE_W-1:0] route_o
);
   localparam int SHARED_N = NUM_IRQ - PRIV_N;

   if (NUM_IRQ % 32 != 0 || NUM_IRQ <= PRIV_N) begin : g_bad_count
      $error("NUM_IRQ must be a multiple of 32 above the private range");
   end
   if (NUM_IRQ > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for NUM_IRQ");
   end

   mask_t mask_all [NUM_IRQ];
   mask_t priv_mask;
   assign priv_mask = MASK_W'(1) << cpu_id;

   for (genvar p = 0; p < PRIV_N; p++) begin : g_priv
      assign mask_o[p*MASK_W +: MASK_W]    = priv_mask;
      assign route_o[p*ROUTE_W +: ROUTE_W] = cpu_id;
      assign mask_all[p]                   = priv_mask;
   end

   for (genvar s = 0; s < SHARED_N; s++) begin : g_shared
      localparam int N = PRIV_N + s;
      itr_entry #(.IRQ_NUM(N), .ADDR_W(ADDR_W)) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .req_valid (req_valid),
         .req_write (req_write),
         .req_word  (req_word),
         .req_addr  (req_addr),
         .req_wdata (req_wdata),
         .mask_o    (mask_o[N*MASK_W +: MASK_W]),
         .route_o   (route_o[N*ROUTE_W +: ROUTE_W])
      );
      assign mask_all[N] = mask_o[N*MASK_W +: MASK_W];
   end

   logic [31:0] rd_next;
   logic        rd_req;
   assign rd_req = req_valid && !req_write;

   always_comb begin
      rd_next = '0;
      for (int i = 0; i < LANES; i++) begin
         logic [ADDR_W-1:0] idx;
         idx = req_word ? {req_addr[ADDR_W-1:2], 2'(i)} : req_addr;
         if (req_word || i == 0) begin
            for (int n = 0; n < NUM_IRQ; n++) begin
               if (idx == ADDR_W'(n)) rd_next[8*i +: 8] = mask_all[n];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) rd_data <= rd_next;
      end
   end

   // R7
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   // R7
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);
   // R7
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rd_data));
endmodule

// File: tb/sim_itr_target_bank.sv
module sim_itr_target_bank;
   localparam int NI = 64;
   localparam int AW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] cpu_id = 3'd5;
   logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rd_data;
   logic rd_valid;
   logic [NI*8-1:0] mask_o;
   logic [NI*3-1:0] route_o;

   int n_chk = 0, n_fail = 0;
   logic [7:0] exp_mask [NI];

   always #10 clk = ~clk;

   itr_target_bank #(.NUM_IRQ(NI), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id), .req_valid(req_valid),
      .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
      .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
      .mask_o(mask_o), .route_o(route_o));

   function automatic logic [2:0] low_idx(input logic [7:0] m);
      for (int k = 0; k < 8; k++) if (m[k]) return 3'(k);
      return 3'd0;
   endfunction

   function automatic logic [7:0] model_mask(input int n);
      if (n < 32) return 8'(1) << cpu_id;
      if (n >= NI) return 8'h00;
      return exp_mask[n];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      int bad = 0;
      for (int n = 0; n < NI; n++) begin
         if (mask_o[n*8 +: 8] !== model_mask(n)) bad++;
         if (route_o[n*3 +: 3] !== low_idx(model_mask(n))) bad++;
      end
      check(req, 32'(bad), 32'd0);
   endtask

   task automatic bus_write(input logic word, input int addr, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_word = word;
      req_addr = AW'(addr); req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      if (word) begin
         for (int i = 0; i < 4; i++) begin
            int n = (addr & ~3) + i;
            if (n >= 32 && n < NI) exp_mask[n] = d[8*i +: 8];
         end
      end else if (addr >= 32 && addr < NI) exp_mask[addr] = d[7:0];
   endtask

   task automatic bus_read(input logic word, input int addr, output logic [31:0] q);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_word = word; req_addr = AW'(addr);
      @(negedge clk);
      req_valid = 1'b0;
      check("R7 rd_valid", 32'(rd_valid), 32'd1);
      q = rd_data;
   endtask

   task automatic t_reset();
      check_all("R1 reset masks/routes");
      check("R1 rd_valid", 32'(rd_valid), 32'd0);
   endtask

   task automatic t_byte();
      bus_write(1'b0, 40, 32'hFFFF_FF2C);
      check("R2 mask 40", 32'(mask_o[40*8 +: 8]), 32'h2C);
      check("R4 route 40", 32'(route_o[40*3 +: 3]), 32'd2);
      bus_write(1'b0, 33, 32'h0000_0080);
      check("R4 route 33", 32'(route_o[33*3 +: 3]), 32'd7);
      check_all("R2 bank after byte writes");
   endtask

   task automatic t_word();
      bus_write(1'b1, 48 + 2, 32'h0081_1001);
      check("R3 mask 49", 32'(mask_o[49*8 +: 8]), 32'h10);
      check("R3 mask 50", 32'(mask_o[50*8 +: 8]), 32'h81);
      check("R4 route 49", 32'(route_o[49*3 +: 3]), 32'd4);
      check("R5 route 51", 32'(route_o[51*3 +: 3]), 32'd0);
      check_all("R3 bank after word write");
   endtask

   task automatic t_zero();
      bus_write(1'b0, 40, 32'h0);
      check("R5 mask 40", 32'(mask_o[40*8 +: 8]), 32'h0);
      check("R5 route 40", 32'(route_o[40*3 +: 3]), 32'd0);
   endtask

   task automatic t_private();
      logic [31:0] q;
      bus_write(1'b1, 4, 32'hFFFF_FFFF);
      bus_write(1'b0, 31, 32'h0000_00FF);
      bus_write(1'b1, 28, 32'h0101_0101);
      check("R6 mask 31", 32'(mask_o[31*8 +: 8]), 32'h20);
      check("R6 route 4", 32'(route_o[4*3 +: 3]), 32'd5);
      bus_read(1'b1, 0, q);
      check("R6 read priv cpu5", q, 32'h2020_2020);
      cpu_id = 3'd2;
      bus_read(1'b1, 28, q);
      check("R6 read priv cpu2", q, 32'h0404_0404);
      check_all("R6 bank after private writes");
   endtask

   task automatic t_read();
      logic [31:0] q;
      bus_read(1'b1, 48, q);
      check("R7 word read 48", q, 32'h0081_1001);
      bus_read(1'b0, 49, q);
      check("R7 byte read 49", q, 32'h0000_0010);
      bus_read(1'b1, 32 + 3, q);
      check("R7 word read 32", q, 32'h0000_8000);
      @(negedge clk);
      check("R7 rd_valid drops", 32'(rd_valid), 32'd0);
   endtask

   task automatic t_oob();
      logic [31:0] q;
      bus_write(1'b1, 60, 32'h4000_0300);
      check("R8 last irq 63", 32'(mask_o[63*8 +: 8]), 32'h40);
      bus_write(1'b0, 64, 32'hFF);
      bus_write(1'b1, 68, 32'hFFFF_FFFF);
      bus_write(1'b0, 1023, 32'hFF);
      check_all("R8 bank after out-of-range writes");
      bus_read(1'b1, 64, q);
      check("R8 word read 64", q, 32'h0);
      bus_read(1'b0, 100, q);
      check("R8 byte read 100", q, 32'h0);
   endtask

   initial begin
      for (int n = 0; n < NI; n++) exp_mask[n] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_byte();
      t_word();
      t_zero();
      t_private();
      t_read();
      t_oob();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule